// File: doc/BRIEF.md
# Range-Adaptive Packed/Truncated Multiplier

This block multiplies two unsigned 32-bit operands through one partial-product array that gating changes from one operation to the next. It has three result formats. Full precision gives the exact 64-bit product. Packed dual-lane mode treats each operand as two independent 16-bit halves and returns both 32-bit lane products side by side. Truncated mode sums only the partial-product bits that land in the upper 32 columns, which yields a cheaper result that never overshoots.

A small selector picks the format for each operation by looking at the magnitude of the two operands. When both operands fit in 16 bits, the packed path is chosen, and with empty upper lanes it returns the exact product. When either operand uses its top byte, the truncated path is chosen. In every other case the full path is used. A forcing input can impose any format. The product, and the format that produced it, appear two clock cycles after the operands are accepted.

Top module: `adaptive_mul`

## Requirements
- R1: In full mode (mode code 00) the product equals the exact unsigned 64-bit product of op_a and op_b.
- R2: In packed mode (mode code 01), product[63:32] = op_a[31:16]×op_b[31:16] and product[31:16+16-16:0] (bits 31..0) = op_a[15:0]×op_b[15:0]; no cross-half term contributes.
- R3: In truncated mode (mode code 10), the product equals the sum of op_a[j]·op_b[i]·2^(i+j) taken over all i+j ≥ 32. Bits 31..0 are therefore zero, and the result never exceeds the exact product.
- R4: With force_en low, packed mode is chosen when op_a[31:16] and op_b[31:16] are both zero.
- R5: With force_en low and R4 not met, truncated mode is chosen when op_a[31:24] or op_b[31:24] is nonzero.
- R6: With force_en low and neither R4 nor R5 met, full mode is chosen.
- R7: With force_en high, force_mode sets the mode (00 full, 01 packed, 10 truncated, 11 full), and the operand ranges are ignored.
- R8: An operation accepted with in_valid high gives out_valid high for exactly one cycle, two rising edges later, and mode_used reports the mode code that was applied.
- R9: While no operation completes, product and mode_used hold their previous values and out_valid stays low.
- R10: After reset, out_valid, product and mode_used are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| force_en | input | 1 | Use force_mode instead of range detection |
| force_mode | input | 2 | Forced mode code |
| out_valid | output | 1 | Result valid pulse |
| product | output | 64 | Result in the selected format |
| mode_used | output | 2 | Mode code that produced product |

## Verification
The hardest situation to reach is packed mode with nonzero upper lanes. Automatic selection never produces it, because it chooses packed mode only when both upper halves are zero, and in that case the packed and exact results agree. A wrong lane mask would therefore go unseen. The stimulus forces packed mode with all-ones and mixed upper halves, so cross-lane leakage would show as a wrong upper word. Truncated mode is also forced with small operands, where every kept term must vanish, and with random wide operands, which are compared against a bitwise column model.

// File: rtl/adaptive_mul_pkg.sv
package adaptive_mul_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_SIMD = 2'b01,
    MODE_APPR = 2'b10
  } mul_mode_t;

  function automatic mul_mode_t decode_force(input logic [1:0] code);
    case (code)
      2'b01:   return MODE_SIMD;
      2'b10:   return MODE_APPR;
      default: return MODE_FULL;
    endcase
  endfunction
endpackage

// File: rtl/range_ctrl.sv
module range_ctrl
  import adaptive_mul_pkg::*;
#(
  parameter int W        = 32,
  parameter int DET_BITS = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         force_en,
  input  logic [1:0]   force_mode,
  output mul_mode_t    mode
);
  localparam int LANE = W / 2;

  logic upper_empty;
  logic top_busy;
  mul_mode_t auto_mode;

  always_comb begin
    upper_empty = ~(|a[W-1:LANE]) & ~(|b[W-1:LANE]);
    top_busy    = (|a[W-1:W-DET_BITS]) | (|b[W-1:W-DET_BITS]);
    if (upper_empty)   auto_mode = MODE_SIMD;
    else if (top_busy) auto_mode = MODE_APPR;
    else               auto_mode = MODE_FULL;
    mode = force_en ? decode_force(force_mode) : auto_mode;
  end
endmodule

// File: rtl/pp_gen.sv
module pp_gen
  import adaptive_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  mul_mode_t      mode,
  output logic [2*W-1:0] rows [W]
);
  localparam int LANE = W / 2;

  logic is_full, is_simd, is_appr;
  assign is_full = (mode == MODE_FULL);
  assign is_simd = (mode == MODE_SIMD);
  assign is_appr = (mode == MODE_APPR);

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0] bits;
    for (genvar j = 0; j < W; j++) begin : g_col
      localparam bit SAME_LANE = ((i < LANE) == (j < LANE));
      localparam bit HIGH_COL  = ((i + j) >= W);
      logic keep;
      assign keep    = is_full | (is_simd & SAME_LANE) | (is_appr & HIGH_COL);
      assign bits[j] = a[j] & b[i] & keep;
    end
    assign rows[i] = {{W{1'b0}}, bits} << i;
  end
endmodule

// File: rtl/pp_reduce.sv
module pp_reduce #(
  parameter int W     = 32,
  parameter int NROWS = 16
) (
  input  logic [2*W-1:0] rows [NROWS],
  output logic [2*W-1:0] sum
);
  always_comb begin
    sum = '0;
    for (int r = 0; r < NROWS; r++) sum = sum + rows[r];
  end
endmodule

// File: rtl/result_mux.sv
module result_mux
  import adaptive_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] lo_sum,
  input  logic [2*W-1:0] hi_sum,
  input  mul_mode_t      mode,
  output logic [2*W-1:0] result
);
  logic [2*W-1:0] total;

  always_comb begin
    total = lo_sum + hi_sum;
    case (mode)
      MODE_SIMD: result = {hi_sum[2*W-1:W], lo_sum[W-1:0]};
      MODE_APPR: result = {total[2*W-1:W], {W{1'b0}}};
      default:   result = total;
    endcase
  end
endmodule

// File: rtl/adaptive_mul.sv
module adaptive_mul
  import adaptive_mul_pkg::*;
#(
  parameter int W        = 32,
  parameter int DET_BITS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           force_en,
  input  logic [1:0]     force_mode,
  output logic           out_valid,
  output logic [2*W-1:0] product,
  output logic [1:0]     mode_used
);
  localparam int LANE  = W / 2;
  localparam int HALF  = W / 2;
  localparam int PW    = 2 * W;

  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  mul_mode_t sel_mode;

  range_ctrl #(.W(W), .DET_BITS(DET_BITS)) u_range (
    .a(op_a), .b(op_b), .force_en(force_en), .force_mode(force_mode), .mode(sel_mode)
  );

  logic         s1_valid, s1_valid_nx;
  logic [W-1:0] s1_a, s1_a_nx, s1_b, s1_b_nx;
  mul_mode_t    s1_mode, s1_mode_nx;

  always_comb begin
    s1_valid_nx = in_valid;
    s1_a_nx     = s1_a;
    s1_b_nx     = s1_b;
    s1_mode_nx  = s1_mode;
    if (in_valid) begin
      s1_a_nx    = op_a;
      s1_b_nx    = op_b;
      s1_mode_nx = sel_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_mode  <= MODE_FULL;
    end else begin
      s1_valid <= s1_valid_nx;
      s1_a     <= s1_a_nx;
      s1_b     <= s1_b_nx;
      s1_mode  <= s1_mode_nx;
    end
  end

  logic [PW-1:0] rows [W];

  pp_gen #(.W(W)) u_pp (.a(s1_a), .b(s1_b), .mode(s1_mode), .rows(rows));

  logic [PW-1:0] part_sum [2];

  for (genvar g = 0; g < 2; g++) begin : g_split
    logic [PW-1:0] grp [HALF];
    for (genvar r = 0; r < HALF; r++) begin : g_take
      assign grp[r] = rows[g*HALF + r];
    end
    pp_reduce #(.W(W), .NROWS(HALF)) u_red (.rows(grp), .sum(part_sum[g]));
  end

  logic [PW-1:0] mux_out;

  result_mux #(.W(W)) u_mux (
    .lo_sum(part_sum[0]), .hi_sum(part_sum[1]), .mode(s1_mode), .result(mux_out)
  );

  logic          out_valid_nx;
  logic [PW-1:0] product_nx;
  logic [1:0]    mode_used_nx;

  always_comb begin
    out_valid_nx = s1_valid;
    product_nx   = product;
    mode_used_nx = mode_used;
    if (s1_valid) begin
      product_nx   = mux_out;
      mode_used_nx = s1_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid <= 1'b0;
      product   <= '0;
      mode_used <= 2'b00;
    end else begin
      out_valid <= out_valid_nx;
      product   <= product_nx;
      mode_used <= mode_used_nx;
    end
  end

  AST_FORCE_PRIO: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && force_en && force_mode != 2'b11) |=> (s1_mode == $past(force_mode))); // R7
  AST_SIMD_PICK: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !force_en && op_a[W-1:LANE] == '0 && op_b[W-1:LANE] == '0) |=> (s1_mode == MODE_SIMD)); // R4
  AST_APPR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && mode_used == 2'b10) |-> (product[W-1:0] == '0)); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_ok)
    s1_valid |=> out_valid); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !s1_valid |=> ($stable(product) && $stable(mode_used) && !out_valid)); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_ok)
    mode_used != 2'b11); // R8
endmodule

// File: tb/adaptive_mul_tb_top.sv
module adaptive_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        force_en;
  logic [1:0]  force_mode;
  logic        out_valid;
  logic [63:0] product;
  logic [1:0]  mode_used;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  adaptive_mul dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .force_en(force_en), .force_mode(force_mode), .out_valid(out_valid),
    .product(product), .mode_used(mode_used)
  );

  // {force_en, force_mode, a, b}
  localparam int NV = 12;
  localparam logic [66:0] VECS [NV] = '{
    {1'b0, 2'b00, 32'h0000_0003, 32'h0000_0005},
    {1'b0, 2'b00, 32'h0001_0000, 32'h0000_0002},
    {1'b0, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 2'b00, 32'h00FF_FFFF, 32'h00FF_FFFF},
    {1'b0, 2'b00, 32'h0000_FFFF, 32'h0000_FFFF},
    {1'b1, 2'b01, 32'h0003_0004, 32'h0005_0006},
    {1'b1, 2'b00, 32'hFFFF_FFFF, 32'h0000_0002},
    {1'b1, 2'b10, 32'h0000_1234, 32'h0000_5678},
    {1'b1, 2'b11, 32'h8000_0000, 32'h0000_0003},
    {1'b0, 2'b00, 32'h0100_0000, 32'h0000_0000},
    {1'b1, 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 2'b00, 32'h0000_0007, 32'h00F0_0000}
  };

  function automatic logic [1:0] exp_mode(logic fe, logic [1:0] fm, logic [31:0] a, logic [31:0] b);
    if (fe) return (fm == 2'b11) ? 2'b00 : fm;   // R7
    if (a[31:16] == 0 && b[31:16] == 0) return 2'b01; // R4
    if (a[31:24] != 0 || b[31:24] != 0) return 2'b10; // R5
    return 2'b00; // R6
  endfunction

  function automatic logic [63:0] approx_ref(logic [31:0] a, logic [31:0] b);
    logic [63:0] s = 64'd0;
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        if ((i + j) >= 32 && a[j] && b[i]) s = s + (64'd1 << (i + j));
    return s;
  endfunction

  function automatic logic [63:0] exp_prod(logic [1:0] m, logic [31:0] a, logic [31:0] b);
    logic [31:0] hi, lo;
    case (m)
      2'b01: begin
        hi = 32'(a[31:16]) * 32'(b[31:16]);
        lo = 32'(a[15:0]) * 32'(b[15:0]);
        return {hi, lo};
      end
      2'b10:   return approx_ref(a, b);
      default: return 64'(a) * 64'(b);
    endcase
  endfunction

  task automatic check64(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(logic fe, logic [1:0] fm, logic [31:0] a, logic [31:0] b,
                        output logic [63:0] got_p, output logic [1:0] got_m, output logic got_v);
    op_a = a; op_b = b; force_en = fe; force_mode = fm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    got_p = product; got_m = mode_used; got_v = out_valid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] p, e, ex;
    logic [1:0]  m, em;
    logic        v;
    real err_sum;

    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; force_en = 1'b0; force_mode = 2'b00;
    repeat (3) @(negedge clk);
    // R10: reset state
    check64("R10 out_valid", 64'(out_valid), 64'd0);
    check64("R10 product", product, 64'd0);
    check64("R10 mode_used", 64'(mode_used), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R1, R2, R3, R4, R5, R6, R7
    for (int k = 0; k < NV; k++) begin
      logic fe; logic [1:0] fm; logic [31:0] a, b;
      {fe, fm, a, b} = VECS[k];
      run_op(fe, fm, a, b, p, m, v);
      em = exp_mode(fe, fm, a, b);
      check64("R4/R5/R6/R7 mode", 64'(m), 64'(em));
      check64("R1/R2/R3 product", p, exp_prod(em, a, b));
      check64("R8 out_valid", 64'(v), 64'd1);
    end

    // R8: exact latency, single pulse
    op_a = 32'h0000_0009; op_b = 32'h0000_0009; force_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64("R8 not early", 64'(out_valid), 64'd0);
    @(negedge clk);
    check64("R8 on time", 64'(out_valid), 64'd1);
    check64("R8 value", product, 64'd81);
    check64("R8 mode code", 64'(mode_used), 64'd1);
    @(negedge clk);
    check64("R8 single pulse", 64'(out_valid), 64'd0);

    // R9: hold while idle, inputs changing but in_valid low
    op_a = 32'hDEAD_BEEF; op_b = 32'hCAFE_F00D; force_en = 1'b1; force_mode = 2'b10;
    repeat (3) @(negedge clk);
    check64("R9 product held", product, 64'd81);
    check64("R9 mode held", 64'(mode_used), 64'd1);
    check64("R9 no valid", 64'(out_valid), 64'd0);

    // R3: forced truncated mode on random operands, error statistics
    err_sum = 0.0;
    for (int k = 0; k < 100; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      run_op(1'b1, 2'b10, a, b, p, m, v);
      ex = 64'(a) * 64'(b);
      e  = approx_ref(a, b);
      check64("R3 truncated value", p, e);
      checks++;
      if (p > ex) begin
        bad++;
        $display("FAIL R3 bound: got %h expected <= %h", p, ex);
      end
      err_sum = err_sum + real'(ex - p);
    end
    $display("truncated mode mean error = %0g", err_sum / 100.0);

    // R1/R2/R4/R5/R6: random automatic selection with varied ranges
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a, b;
      a = $urandom >> (k % 24); b = $urandom >> ((k * 7) % 24);
      run_op(1'b0, 2'b00, a, b, p, m, v);
      em = exp_mode(1'b0, 2'b00, a, b);
      check64("R4/R5/R6 random mode", 64'(m), 64'(em));
      check64("R1/R2/R3 random product", p, exp_prod(em, a, b));
    end

    // R2: forced packed mode with random upper lanes
    for (int k = 0; k < 30; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      run_op(1'b1, 2'b01, a, b, p, m, v);
      check64("R2 packed lanes", p, exp_prod(2'b01, a, b));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule